// File: doc/BRIEF.md
# Vector Memory Request Coalescer

This block sits between a 16-lane vector execution unit and the memory channels. One memory instruction arrives as a single transfer holding, for every lane, an enable, a byte address and an access size (one 32-bit word or one 128-bit quad). The block merges all enabled lanes whose addresses lie in the same aligned 256-byte region into one wide request. That request carries the region base address, a byte-enable mask of the bytes the lanes touch, and the memory channel that the region maps to.

When the enabled lanes span several regions, the block emits one request per distinct region, one after another, on a valid/ready output stream. A region is served in the order of the lowest-numbered lane it contains. The input stays blocked until the final request of the instruction has been taken downstream, so instructions never overlap. Access addresses are treated as naturally aligned to their size: the address bits below the access size do not select bytes.

Top module: `vec_mem_coalescer`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: Sixteen enabled 128-bit lanes whose addresses cover one aligned 256-byte region contiguously produce exactly one request, with all 256 mask bits set and out_last set.
- R3: Bit b of out_byte_en stands for byte b of the region. A 32-bit lane (in_lane_wide=0) sets bits 4*addr[7:2] to 4*addr[7:2]+3. A 128-bit lane (in_lane_wide=1) sets bits 16*addr[7:4] to 16*addr[7:4]+15. Address bits below the access size are ignored.
- R4: Enabled lanes whose addresses differ in bits [31:8] are put into separate requests, one request per distinct region. Each request has out_base equal to the region address with bits [7:0] zero.
- R5: The requests of one instruction leave in ascending order of the lowest lane index each one contains.
- R6: While out_valid is 1 and out_ready is 0, out_valid stays 1 and out_base, out_byte_en and out_chan keep their values.
- R7: An instruction with at least one enabled lane is accepted when in_valid and in_ready are both 1. From then on in_ready is 0 until the request flagged out_last has been accepted. In the cycle after that, in_ready is 1.
- R8: Lanes with in_lane_en at 0 add no bytes and no requests. An accepted instruction with no enabled lane produces no request, and in_ready stays 1.
- R9: out_chan equals address bits [10:8] of the request's region (CHAN_W=3 bits directly above the 8-bit byte field).
- R10: Sixteen enabled 32-bit lanes at consecutive word addresses inside one region produce one request with 64 mask bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction valid |
| in_ready | output | 1 | Block can accept an instruction |
| in_lane_en | input | 16 | Per-lane enable |
| in_lane_wide | input | 16 | Per-lane size: 1 = 128 bit, 0 = 32 bit |
| in_lane_addr | input | 512 | Lane byte addresses, lane i at bits [32*i+31:32*i] |
| out_valid | output | 1 | Request valid |
| out_ready | input | 1 | Downstream accepts the request |
| out_base | output | 32 | Region base address, low 8 bits zero |
| out_byte_en | output | 256 | Bytes touched within the region |
| out_chan | output | 3 | Memory channel of the region |
| out_last | output | 1 | Final request of the current instruction |

## Verification
The hardest situation to reach from the ports is a long split sequence held under back-pressure. There the leader lane, the mask and the channel must stay fixed over stalled cycles, and the input must stay blocked. A directed instruction with lanes in three separate regions is issued with out_ready held low for several cycles before draining. Stride tables place lanes across region boundaries partway through the lane vector, and one entry uses a stride of one region per lane to walk every channel value. Lanes that are partly enabled or misaligned exercise the mask rules.

// File: rtl/coal_pkg.sv
package coal_pkg;
   // Access size encoding of one lane
   typedef enum logic {
      SZ_WORD = 1'b0,
      SZ_QUAD = 1'b1
   } acc_size_e;

   localparam int WORD_BYTES = 4;
   localparam int QUAD_BYTES = 16;
endpackage

// File: rtl/coal_first_lane.sv
module coal_first_lane #(
   parameter int N     = 16,
   localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]     req,
   output logic [IDX_W-1:0] idx
);
   // Lowest-index set bit wins
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IDX_W'(i);
      end
   end
endmodule

// File: rtl/coal_lane_slot.sv
module coal_lane_slot
   import coal_pkg::*;
#(
   parameter int ADDR_W      = 32,
   parameter int REGION_BITS = 8,
   localparam int TAG_W  = ADDR_W - REGION_BITS,
   localparam int WORDS  = (1 << REGION_BITS) / WORD_BYTES,
   localparam int WIDX_W = REGION_BITS - 2
) (
   input  logic [ADDR_W-1:0] addr,
   input  acc_size_e         size,
   input  logic              pending,
   input  logic [TAG_W-1:0]  lead_tag,
   output logic              match,
   output logic [WORDS-1:0]  word_en
);
   logic [WIDX_W-1:0] word_idx;
   logic [WIDX_W-3:0] quad_idx;
   logic [1:0]        addr_unused;

   assign addr_unused = addr[1:0];
   assign word_idx    = addr[REGION_BITS-1:2];
   assign quad_idx    = addr[REGION_BITS-1:4];
   assign match       = pending && (addr[ADDR_W-1:REGION_BITS] == lead_tag);

   for (genvar w = 0; w < WORDS; w++) begin : g_word
      localparam logic [WIDX_W-1:0] W_IDX = WIDX_W'(w);
      always_comb begin
         if (!match)
            word_en[w] = 1'b0;
         else if (size == SZ_QUAD)
            word_en[w] = (W_IDX[WIDX_W-1:2] == quad_idx);
         else
            word_en[w] = (W_IDX == word_idx);
      end
   end
endmodule

// File: rtl/vec_mem_coalescer.sv
module vec_mem_coalescer
   import coal_pkg::*;
#(
   parameter int LANES       = 16,
   parameter int ADDR_W      = 32,
   parameter int REGION_BITS = 8,
   parameter int CHAN_W      = 3,
   localparam int REGION_BYTES = 1 << REGION_BITS,
   localparam int WORDS        = REGION_BYTES / WORD_BYTES,
   localparam int TAG_W        = ADDR_W - REGION_BITS,
   localparam int IDX_W        = (LANES > 1) ? $clog2(LANES) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      in_valid,
   output logic                      in_ready,
   input  logic [LANES-1:0]          in_lane_en,
   input  logic [LANES-1:0]          in_lane_wide,
   input  logic [LANES*ADDR_W-1:0]   in_lane_addr,
   output logic                      out_valid,
   input  logic                      out_ready,
   output logic [ADDR_W-1:0]         out_base,
   output logic [REGION_BYTES-1:0]   out_byte_en,
   output logic [CHAN_W-1:0]         out_chan,
   output logic                      out_last
);
   // Elaboration-time parameter checks
   if (LANES < 2) begin : g_bad_lanes
      $error("LANES must be at least 2");
   end
   if (REGION_BITS < 5) begin : g_bad_region
      $error("REGION_BITS must hold at least two quads");
   end
   if (CHAN_W < 1 || REGION_BITS + CHAN_W > ADDR_W) begin : g_bad_chan
      $error("channel slice must fit above the region field");
   end

   logic                    busy_q;
   logic [LANES-1:0]        pending_q;
   logic [LANES-1:0]        wide_q;
   logic [LANES*ADDR_W-1:0] addr_q;

   logic [IDX_W-1:0]        lead_idx;
   logic [TAG_W-1:0]        lead_tag;
   logic [LANES-1:0]        match;
   logic [WORDS-1:0]        lane_words [LANES];
   logic [WORDS-1:0]        word_en;
   logic                    accept;
   logic                    drain;

   assign accept = in_valid && in_ready;
   assign drain  = busy_q && out_ready;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q    <= 1'b0;
         pending_q <= '0;
      end else if (accept) begin
         busy_q    <= |in_lane_en;
         pending_q <= in_lane_en;
      end else if (drain) begin
         pending_q <= pending_q & ~match;
         if (out_last) busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (accept) begin
         addr_q <= in_lane_addr;
         wide_q <= in_lane_wide;
      end
   end

   coal_first_lane #(.N(LANES)) i_first (
      .req (pending_q),
      .idx (lead_idx)
   );

   assign lead_tag = addr_q[int'(lead_idx)*ADDR_W + REGION_BITS +: TAG_W];

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      coal_lane_slot #(
         .ADDR_W      (ADDR_W),
         .REGION_BITS (REGION_BITS)
      ) i_slot (
         .addr     (addr_q[l*ADDR_W +: ADDR_W]),
         .size     (acc_size_e'(wide_q[l])),
         .pending  (pending_q[l]),
         .lead_tag (lead_tag),
         .match    (match[l]),
         .word_en  (lane_words[l])
      );
   end

   always_comb begin
      word_en = '0;
      for (int l = 0; l < LANES; l++) word_en = word_en | lane_words[l];
   end

   for (genvar b = 0; b < REGION_BYTES; b++) begin : g_byte
      assign out_byte_en[b] = word_en[b / WORD_BYTES];
   end

   assign in_ready  = !busy_q;
   assign out_valid = busy_q;
   assign out_base  = {lead_tag, {REGION_BITS{1'b0}}};
   assign out_chan  = addr_q[int'(lead_idx)*ADDR_W + REGION_BITS +: CHAN_W];
   assign out_last  = ((pending_q & ~match) == '0);

   // R6: stalled request holds its content
   p_hold_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_base)
                                  && $stable(out_byte_en) && $stable(out_chan));

   // R3: every request touches at least one byte
   p_mask_nonempty_r3: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (|out_byte_en));

   // R4: a non-final accepted request is followed by another one
   p_split_continues_r4: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && !out_last |=> out_valid && !in_ready);

   // R7: input reopens right after the final request is taken
   p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready && out_last |=> in_ready && !out_valid);

   // R9: channel agrees with the region address
   p_chan_slice_r9: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> out_chan == out_base[REGION_BITS +: CHAN_W]);

   // R8: an instruction with no enabled lane leaves the block idle
   p_empty_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid && in_ready && !(|in_lane_en) |=> in_ready && !out_valid);
endmodule

// File: tb/test_vec_mem_coalescer.sv
module test_vec_mem_coalescer;
   localparam int LANES = 16;

   logic                  clk = 1'b0;
   logic                  rst_n = 1'b0;
   logic                  in_valid = 1'b0;
   logic                  in_ready;
   logic [LANES-1:0]      in_lane_en = '0;
   logic [LANES-1:0]      in_lane_wide = '0;
   logic [LANES*32-1:0]   in_lane_addr = '0;
   logic                  out_valid;
   logic                  out_ready = 1'b1;
   logic [31:0]           out_base;
   logic [255:0]          out_byte_en;
   logic [2:0]            out_chan;
   logic                  out_last;

   int checks = 0;
   int errors = 0;
   int cycles = 0;

   logic [31:0] la [LANES];
   logic        lw [LANES];
   logic        le [LANES];

   always #2.5 clk = ~clk;

   vec_mem_coalescer i_vec_mem_coalescer (
      .clk, .rst_n, .in_valid, .in_ready, .in_lane_en, .in_lane_wide,
      .in_lane_addr, .out_valid, .out_ready, .out_base, .out_byte_en,
      .out_chan, .out_last
   );

   // base, stride, wide, enable, expected request count
   localparam logic [87:0] VEC [7] = '{
      {32'h0000_1000, 32'd16,  1'b1, 16'hFFFF, 7'd1},   // R2
      {32'h0000_2040, 32'd4,   1'b0, 16'hFFFF, 7'd1},   // R10
      {32'h0000_30C0, 32'd16,  1'b1, 16'hFFFF, 7'd2},   // R4
      {32'h0000_4000, 32'd256, 1'b0, 16'hFFFF, 7'd16},  // R5 R9
      {32'h0000_5000, 32'd16,  1'b1, 16'h00F0, 7'd1},   // R8
      {32'h0000_6000, 32'd4,   1'b0, 16'h0000, 7'd0},   // R8
      {32'h0000_7000, 32'd0,   1'b0, 16'hFFFF, 7'd1}    // R3
   };

   task automatic check(input bit ok, input string req, input string what,
                        input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic issue();
      @(negedge clk);
      check(in_ready == 1'b1, "R7", "ready before issue", 256'(in_ready), 256'd1);
      for (int i = 0; i < LANES; i++) begin
         in_lane_addr[i*32 +: 32] = la[i];
         in_lane_wide[i] = lw[i];
         in_lane_en[i]   = le[i];
      end
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   // Drain requests and compare with a model built from the requirements
   task automatic collect(input int exp_n, input string req);
      bit          rem [LANES];
      int          n = 0;
      for (int i = 0; i < LANES; i++) rem[i] = le[i];
      for (int g = 0; g < 200; g++) begin
         if (out_valid) begin
            int          first = -1;
            logic [31:0] reg_b;
            logic [255:0] m = '0;
            bit          more = 1'b0;
            for (int i = LANES - 1; i >= 0; i--) if (rem[i]) first = i;
            if (first < 0) begin
               check(1'b0, req, "extra request", 256'(out_base), 256'd0);
            end else begin
               reg_b = la[first] & 32'hFFFF_FF00;
               for (int i = 0; i < LANES; i++) begin
                  if (rem[i] && (la[i] & 32'hFFFF_FF00) == reg_b) begin
                     if (lw[i]) for (int k = 0; k < 16; k++) m[{la[i][7:4], 4'b0} + k] = 1'b1;
                     else       for (int k = 0; k < 4; k++)  m[{la[i][7:2], 2'b0} + k] = 1'b1;
                     rem[i] = 1'b0;
                  end
               end
               for (int i = 0; i < LANES; i++) if (rem[i]) more = 1'b1;
               check(out_base == reg_b, "R5", "request base", 256'(out_base), 256'(reg_b));
               check(out_byte_en == m, "R3", "byte mask", out_byte_en, m);
               check(out_chan == reg_b[10:8], "R9", "channel", 256'(out_chan), 256'(reg_b[10:8]));
               check(out_last == !more, "R7", "last flag", 256'(out_last), 256'(!more));
            end
            n++;
         end else if (in_ready) begin
            break;
         end
         @(negedge clk);
      end
      check(n == exp_n, req, "request count", 256'(n), 256'(exp_n));
      check(in_ready == 1'b1, "R7", "ready after drain", 256'(in_ready), 256'd1);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 100000) begin
         check(1'b0, "R7", "watchdog expired", 256'(cycles), 256'd0);
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1", "reset in_ready", 256'(in_ready), 256'd1);
      check(out_valid == 1'b0, "R1", "reset out_valid", 256'(out_valid), 256'd0);

      // Table-driven cases
      for (int v = 0; v < 7; v++) begin
         for (int i = 0; i < LANES; i++) begin
            la[i] = VEC[v][87:56] + i * VEC[v][55:24];
            lw[i] = VEC[v][23];
            le[i] = VEC[v][7 + i];
         end
         issue();
         collect(int'(VEC[v][6:0]), v == 0 ? "R2" : v == 1 ? "R10" : v == 2 ? "R4" :
                 v == 3 ? "R5" : v == 6 ? "R3" : "R8");
      end

      // R3: misaligned low address bits are ignored
      for (int i = 0; i < LANES; i++) begin la[i] = 32'h9000; lw[i] = 1'b0; le[i] = 1'b0; end
      la[0] = 32'h0000_9007; lw[0] = 1'b1; le[0] = 1'b1;
      la[1] = 32'h0000_9023; lw[1] = 1'b0; le[1] = 1'b1;
      issue();
      collect(1, "R3");

      // R6 R7: back-pressure on a three-region split
      for (int i = 0; i < LANES; i++) begin la[i] = 32'hA000 + i * 256; lw[i] = 1'b0; le[i] = (i < 3); end
      out_ready = 1'b0;
      issue();
      for (int s = 0; s < 3; s++) begin
         check(out_valid == 1'b1, "R6", "valid held", 256'(out_valid), 256'd1);
         check(out_base == 32'hA000, "R6", "base held", 256'(out_base), 256'h A000);
         check(in_ready == 1'b0, "R7", "input blocked", 256'(in_ready), 256'd0);
         @(negedge clk);
      end
      out_ready = 1'b1;
      collect(3, "R4");

      // R8: disabled lanes in other regions do not split the request
      for (int i = 0; i < LANES; i++) begin la[i] = 32'hB000 + i * 256; lw[i] = 1'b1; le[i] = (i == 5); end
      issue();
      collect(1, "R8");

      finish_run();
   end
endmodule